// File: doc/BRIEF.md
# Sliding-Window Address Sequencer

The block produces a stream of 16-bit memory addresses for a data-driven array, one address per clock. It is built from three copies of one generic stepper: the address stepper, which walks an inner run from a base toward a limit; the base slider, which moves the base between runs; and the limit slider, which moves the limit between runs. Each stepper has a value register, a signed step vector, a step counter with a maximum count, and end detection. The sliders shift the window after every completed inner run, so a single configuration describes a linear scan, a nested scan or a sliding-window scan.

Software-visible state is limited to a configuration strobe that latches the initial base, initial limit, three step vectors and three maximum counts. A start pulse begins the scan. The block then emits addresses with a valid flag until one of the sliders runs out of steps, and it raises an end flag. A registered escape input can cut the current inner run short.

Top module: `gau_slider_top`

## Requirements
- R1: A high `cfg_load` latches all `cfg_*` inputs, stops any scan in progress and clears `end_exec`. Valid is low in the cycle after a `cfg_load` that arrives during a scan. A `start` pulse while idle begins a scan. The first address, equal to the latched initial base, appears with `addr_valid` high in the cycle after the edge that samples `start`.
- R2: Within an inner run, each valid address equals the previous one plus the address step vector, taken as a signed 16-bit two's-complement value.
- R3: An inner run emits at most `cfg_addr_cnt` addresses. A count of 0 behaves as 1.
- R4: The step direction is the sign bit of the address step vector. A run ends without emitting the next address when that address would exceed the current limit (non-negative step) or fall below it (negative step). The first address of a run is emitted unconditionally.
- R5: When an inner run ends and the scan continues, the base moves by the base step vector and the limit by the limit step vector. The next run starts at the new base in the very next cycle, with no idle cycle in between.
- R6: The scan finishes at the end of the inner run in which the base slider has completed `cfg_base_cnt` runs or the limit slider has completed `cfg_limit_cnt` runs, whichever comes first (0 behaves as 1). `end_exec` then rises, `addr_valid` stays low, and `end_exec` holds until the next `start` or `cfg_load`.
- R7: `escape` is registered. In the cycle after it is sampled high during a scan, no address is emitted and the current inner run ends. The sliders then advance as after a normal run end.
- R8: A `start` pulse during a scan is ignored, and the address sequence continues unchanged.
- R9: After reset, `addr_valid` and `end_exec` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Latch configuration, abort scan |
| cfg_base | input | 16 | Initial base |
| cfg_limit | input | 16 | Initial limit |
| cfg_addr_step | input | 16 | Signed address step vector |
| cfg_addr_cnt | input | 16 | Maximum addresses per inner run |
| cfg_base_step | input | 16 | Signed base slider step vector |
| cfg_limit_step | input | 16 | Signed limit slider step vector |
| cfg_base_cnt | input | 16 | Maximum runs for the base slider |
| cfg_limit_cnt | input | 16 | Maximum runs for the limit slider |
| start | input | 1 | Begin a scan when idle |
| escape | input | 1 | Early termination of the current inner run |
| addr | output | 16 | Current address |
| addr_valid | output | 1 | `addr` is a scan address this cycle |
| end_exec | output | 1 | Scan finished (sticky) |

## Verification
The embedded assertions check the following properties on every cycle:
- no valid address past the limit once a run has stepped;
- the inner step count stays below its maximum, and each slider's count stays below its own maximum;
- every new run starts at the current base;
- an escape cycle is silent and ends the run;
- `end_exec` stays sticky;
- a `start` pulse during a scan is ignored.

Only the bench's scenarios can show the full ordered address streams against a nested-loop model. These scenarios cover an ascending linear scan, a count-limited run, a sliding window, a descending window in which the limit slider ends first, and a truncated middle run. They also show the absence of gaps between runs, the abort by `cfg_load`, and the rerun after completion.

// File: rtl/gau_stepper.sv
module gau_stepper #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  input  logic [W-1:0] vec,
  input  logic [W-1:0] max_cnt,
  input  logic         chk_bound,
  input  logic [W-1:0] bound,
  output logic [W-1:0] val,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam int SW = W + 2;

  logic signed [SW-1:0] sum;
  logic                 passes;

  assign sum    = $signed({2'b00, val}) + $signed({{2{vec[W-1]}}, vec});
  assign passes = vec[W-1] ? (sum < $signed({2'b00, bound}))
                           : (sum > $signed({2'b00, bound}));
  assign last   = ({1'b0, cnt} + 1'b1 >= {1'b0, max_cnt}) || (chk_bound && passes);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
      cnt <= '0;
    end else if (load) begin
      val <= load_val;
      cnt <= '0;
    end else if (adv) begin
      val <= sum[W-1:0];
      cnt <= cnt + 1'b1;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load |=> val == $past(val) + $past(vec));
endmodule

// File: rtl/gau_slider_top.sv
module gau_slider_top #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_load,
  input  logic [W-1:0] cfg_base,
  input  logic [W-1:0] cfg_limit,
  input  logic [W-1:0] cfg_addr_step,
  input  logic [W-1:0] cfg_addr_cnt,
  input  logic [W-1:0] cfg_base_step,
  input  logic [W-1:0] cfg_limit_step,
  input  logic [W-1:0] cfg_base_cnt,
  input  logic [W-1:0] cfg_limit_cnt,
  input  logic         start,
  input  logic         escape,
  output logic [W-1:0] addr,
  output logic         addr_valid,
  output logic         end_exec
);
  logic [W-1:0] b0_q, l0_q, da_q, acnt_q, db_q, dl_q, bcnt_q, lcnt_q;
  logic         running, done_q, esc_q;
  logic [W-1:0] a_val, a_cnt, b_val, b_cnt, l_val, l_cnt;
  logic         a_last, b_last, l_last;
  logic         go, run_end, fin;

  assign go         = start && !running && !cfg_load;
  assign run_end    = running && (esc_q || a_last);
  assign fin        = run_end && (b_last || l_last);
  assign addr       = a_val;
  assign addr_valid = running && !esc_q;
  assign end_exec   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {b0_q, l0_q, da_q, acnt_q} <= '0;
      {db_q, dl_q, bcnt_q, lcnt_q} <= '0;
      running <= 1'b0;
      done_q  <= 1'b0;
      esc_q   <= 1'b0;
    end else begin
      esc_q <= escape;
      if (cfg_load) begin
        b0_q    <= cfg_base;
        l0_q    <= cfg_limit;
        da_q    <= cfg_addr_step;
        acnt_q  <= cfg_addr_cnt;
        db_q    <= cfg_base_step;
        dl_q    <= cfg_limit_step;
        bcnt_q  <= cfg_base_cnt;
        lcnt_q  <= cfg_limit_cnt;
        running <= 1'b0;
        done_q  <= 1'b0;
      end else if (go) begin
        running <= 1'b1;
        done_q  <= 1'b0;
      end else if (fin) begin
        running <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  gau_stepper #(.W(W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(go || (run_end && !fin)),
    .load_val(go ? b0_q : b_val + db_q),
    .adv(running && !run_end),
    .vec(da_q), .max_cnt(acnt_q),
    .chk_bound(1'b1), .bound(l_val),
    .val(a_val), .cnt(a_cnt), .last(a_last)
  );

  gau_stepper #(.W(W)) u_base (
    .clk(clk), .rst_n(rst_n),
    .load(go), .load_val(b0_q),
    .adv(run_end && !fin),
    .vec(db_q), .max_cnt(bcnt_q),
    .chk_bound(1'b0), .bound('0),
    .val(b_val), .cnt(b_cnt), .last(b_last)
  );

  gau_stepper #(.W(W)) u_limit (
    .clk(clk), .rst_n(rst_n),
    .load(go), .load_val(l0_q),
    .adv(run_end && !fin),
    .vec(dl_q), .max_cnt(lcnt_q),
    .chk_bound(1'b0), .bound('0),
    .val(l_val), .cnt(l_cnt), .last(l_last)
  );

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> running && a_val == b0_q && a_cnt == '0 && !end_exec);

  p_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (acnt_q == '0 ? a_cnt == '0 : a_cnt < acnt_q));

  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && a_cnt != '0 |-> (da_q[W-1] ? addr >= l_val : addr <= l_val));

  p_next_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_end && !fin && !cfg_load |=> running && a_cnt == '0 && a_val == b_val);

  p_slide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (bcnt_q == '0 ? b_cnt == '0 : b_cnt < bcnt_q) &&
                (lcnt_q == '0 ? l_cnt == '0 : l_cnt < lcnt_q));

  p_end_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_exec |-> !addr_valid);

  p_end_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_exec && !start && !cfg_load |=> end_exec);

  p_escape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running && esc_q && !cfg_load |=> !running || a_cnt == '0);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running && start && !run_end && !cfg_load |=> running && a_cnt == $past(a_cnt) + 1'b1);
endmodule

// File: tb/tb_gau_slider_top.sv
`timescale 1ns/1ps
module tb_gau_slider_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0, start = 1'b0, escape = 1'b0;
  logic [15:0] cfg_base = '0, cfg_limit = '0, cfg_addr_step = '0, cfg_addr_cnt = '0;
  logic [15:0] cfg_base_step = '0, cfg_limit_step = '0, cfg_base_cnt = '0, cfg_limit_cnt = '0;
  logic [15:0] addr;
  logic        addr_valid, end_exec;

  int checks = 0, failures = 0;
  logic [15:0] exp_q [0:255];
  int exp_n, esc_pos;

  always #2.5 clk = ~clk;

  gau_slider_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_addr_step(cfg_addr_step), .cfg_addr_cnt(cfg_addr_cnt),
    .cfg_base_step(cfg_base_step), .cfg_limit_step(cfg_limit_step),
    .cfg_base_cnt(cfg_base_cnt), .cfg_limit_cnt(cfg_limit_cnt),
    .start(start), .escape(escape),
    .addr(addr), .addr_valid(addr_valid), .end_exec(end_exec)
  );

  // {base0, limit0, astep, acnt, bstep, lstep, bcnt, lcnt, esc_run, esc_after}
  localparam logic [159:0] VEC [5] = '{
    {16'h0100, 16'h010F, 16'h0001, 16'd100, 16'h0000, 16'h0000, 16'd1, 16'd1, 16'd0, 16'd0},
    {16'h2000, 16'hFFFF, 16'h0004, 16'd5,   16'h0000, 16'h0000, 16'd1, 16'd1, 16'd0, 16'd0},
    {16'h0010, 16'h0013, 16'h0001, 16'd50,  16'h0002, 16'h0002, 16'd4, 16'd9, 16'd0, 16'd0},
    {16'h0050, 16'h0040, 16'hFFFC, 16'd50,  16'h0010, 16'h0010, 16'd3, 16'd2, 16'd0, 16'd0},
    {16'h0000, 16'h0007, 16'h0001, 16'd20,  16'h0008, 16'h0008, 16'd3, 16'd3, 16'd1, 16'd3}
  };
  localparam string VNAME [5] = '{"R4 linear", "R3 count", "R5 sliding", "R6 descending", "R7 escape"};

  function automatic logic [15:0] fld(input logic [159:0] e, input int i);
    return e[159 - 16*i -: 16];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [159:0] e);
    logic [15:0] b, l, a, da;
    int nr, nx, k, acnt;
    da   = fld(e, 2);
    acnt = int'(fld(e, 3));
    nr   = (fld(e, 6) < fld(e, 7)) ? int'(fld(e, 6)) : int'(fld(e, 7));
    if (nr == 0) nr = 1;
    exp_n = 0; esc_pos = 0;
    for (int r = 0; r < nr; r++) begin
      b = fld(e, 0) + 16'(r) * fld(e, 4);
      l = fld(e, 1) + 16'(r) * fld(e, 5);
      a = b; k = 0;
      forever begin
        if (fld(e, 9) != 0 && r == int'(fld(e, 8)) && k == int'(fld(e, 9))) begin
          esc_pos = exp_n; break;
        end
        exp_q[exp_n] = a; exp_n++; k++;
        if (k >= acnt) break;
        nx = int'(a) + int'($signed(da));
        if ($signed(da) < 0 ? nx < int'(l) : nx > int'(l)) break;
        a = nx[15:0];
      end
    end
  endtask

  task automatic configure(input logic [159:0] e);
    cfg_base = fld(e, 0); cfg_limit = fld(e, 1); cfg_addr_step = fld(e, 2);
    cfg_addr_cnt = fld(e, 3); cfg_base_step = fld(e, 4); cfg_limit_step = fld(e, 5);
    cfg_base_cnt = fld(e, 6); cfg_limit_cnt = fld(e, 7);
    cfg_load = 1'b1; @(negedge clk); cfg_load = 1'b0;
    build(e);
  endtask

  // restart_at > 0 pulses start again after that many addresses (R8)
  task automatic run_scan(input string tag, input int restart_at);
    int idx = 0, gaps = 0, cyc = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(addr_valid === 1'b1 && addr === exp_q[0], {tag, " R1 first"}, addr, exp_q[0]);
    while (!end_exec && cyc < 2000) begin
      start = 1'b0;
      escape = 1'b0;
      if (addr_valid) begin
        if (idx < exp_n)
          chk(addr === exp_q[idx], {tag, " R2 addr"}, addr, exp_q[idx]);
        idx++;
        if (esc_pos != 0 && idx == esc_pos) escape = 1'b1;
        if (restart_at != 0 && idx == restart_at) start = 1'b1;
      end else gaps++;
      @(negedge clk); cyc++;
    end
    escape = 1'b0; start = 1'b0;
    chk(idx == exp_n, {tag, " R6 count"}, idx, exp_n);
    chk(gaps == (esc_pos != 0 ? 1 : 0), {tag, " R5 gaps"}, gaps, esc_pos != 0 ? 1 : 0);
    chk(end_exec === 1'b1 && addr_valid === 1'b0, {tag, " R6 end"}, end_exec, 1);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(addr_valid === 1'b0 && end_exec === 1'b0, "R9 in reset", {addr_valid, end_exec}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_valid === 1'b0 && end_exec === 1'b0, "R9 after reset", {addr_valid, end_exec}, 0);

    for (int i = 0; i < 5; i++) begin
      configure(VEC[i]);
      run_scan(VNAME[i], 0);
    end

    // R6 sticky end flag, then R1 restart reproduces the scan
    repeat (3) @(negedge clk);
    chk(end_exec === 1'b1 && addr_valid === 1'b0, "R6 sticky", end_exec, 1);
    run_scan("R1 rerun", 0);

    // R8 start during scan ignored
    configure(VEC[0]);
    run_scan("R8 restart", 5);

    // R1 cfg_load aborts a running scan
    configure(VEC[2]);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk(addr_valid === 1'b1, "R1 running", addr_valid, 1);
    cfg_load = 1'b1; @(negedge clk); cfg_load = 1'b0;
    chk(addr_valid === 1'b0 && end_exec === 1'b0, "R1 abort", {addr_valid, end_exec}, 0);
    repeat (3) @(negedge clk);
    chk(addr_valid === 1'b0, "R1 stays idle", addr_valid, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule